// File: doc/BRIEF.md
# Period-Adaptive Crank Edge Deglitch Filter

This block cleans up a digital crank-wheel sensor signal that already arrives synchronized to the system clock. It times the most recent reference pulse in clock cycles. From that length it derives a rejection window of about one percent. Any rising or falling transition on the input must then hold for longer than the window before it reaches the filtered output. As the wheel speeds up or slows down, the window follows the tooth period, so the filter tracks engine speed with no fixed constant.

The reference pulse is either the high phase or the low phase of the input. The high phase suits a wheel with missing teeth; the low phase suits a wheel with one elongated tooth. A small configuration byte, written over a plain parallel write strobe and readable at all times, holds three controls: the filter enable, the reference-phase select, and a conditioning-off switch. The last latched pulse length is visible as a read-only status value.

Top module: `crank_deglitch`

## Requirements
- R1: After synchronous reset, `dout` is 0, `ref_count` is 0, and `cfg_rdata` is 0x00.
- R2: A write with `cfg_we` high captures the configuration. Bit 0 is conditioning-off, bit 1 selects the low phase as reference, and bit 3 enables the filter. `cfg_rdata` shows those three bits in the same positions from the next cycle, and its other bits always read 0.
- R3: With the filter enable at 0 and conditioning active, `dout` equals the `din` of the previous cycle.
- R4: With the select bit at 0, `ref_count` takes the number of consecutive cycles `din` was high. It is latched at the clock edge that samples `din` low again. Only pulses whose start was observed count.
- R5: With the select bit at 1, `ref_count` times the low phase of `din` in the same manner.
- R6: The pulse counter saturates at 2^CNT_W-1, so a longer pulse reports that value.
- R7: The window is the latched count divided by 100 and rounded down. It uses a reciprocal multiply that is exact to within 0.1%, and it takes effect one cycle after the latch.
- R8: With the filter enabled, a rise of `din` while `dout` is 0 reaches `dout` only if `din` stays high for more than the window's number of sampled cycles. A shorter high excursion leaves `dout` at 0.
- R9: With the filter enabled, a fall of `din` while `dout` is 1 obeys the same rule in the opposite direction.
- R10: After reset, and until a first complete reference pulse has been latched, the window is 0, so a single-cycle excursion passes with one cycle of latency.
- R11: While conditioning-off is 1, `dout` is 0 and `ref_count` is cleared one cycle after the bit is written, and `din` has no effect on either. When the bit is cleared again, the window restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Synchronized raw sensor level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| dout | output | 1 | Filtered sensor level |
| ref_count | output | CNT_W | Last latched reference-pulse length |

## Verification
The bench drives excursions of exactly the window length and of one cycle more, in both edge directions. A filter that is off by one in its stability compare lets the first pass or holds back the second. It times pulses far longer than the counter range to expose wrap-around, which would collapse the window. Randomly sized pulses check the divide-by-100 window, and each is followed by a glitch sized around that window. After disabling, the bench toggles the input and then re-enables, to catch a measured period that survives the off state or an output that follows the input while off.

// File: rtl/crank_pkg.sv
package crank_pkg;
  localparam int CFG_W      = 8;
  localparam int BIT_OFF    = 0;
  localparam int BIT_SEL_LO = 1;
  localparam int BIT_EN     = 3;

  typedef struct packed {
    logic filt_en;
    logic sel_low;
    logic cond_off;
  } cfg_t;
endpackage

// File: rtl/crank_cfg_reg.sv
module crank_cfg_reg
  import crank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);
  localparam logic [CFG_W-1:0] WR_MASK =
    CFG_W'((1 << BIT_OFF) | (1 << BIT_SEL_LO) | (1 << BIT_EN));

  logic [CFG_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else if (we) reg_q <= wdata & WR_MASK;
  end

  assign rdata         = reg_q;
  assign cfg.filt_en   = reg_q[BIT_EN];
  assign cfg.sel_low   = reg_q[BIT_SEL_LO];
  assign cfg.cond_off  = reg_q[BIT_OFF];

  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata == ($past(wdata) & WR_MASK));
endmodule

// File: rtl/crank_pulse_timer.sv
module crank_pulse_timer #(
  parameter int CNT_W = 20,
  parameter int RECIP = 656,
  parameter int SHIFT = 16,
  localparam int WIN_W = CNT_W - 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             off,
  input  logic             sel_low,
  output logic [CNT_W-1:0] ref_q,
  output logic [WIN_W-1:0] win
);
  localparam int PW = CNT_W + SHIFT;
  localparam logic [CNT_W-1:0] CMAX    = '1;
  localparam logic [PW-1:0]    RECIP_V = PW'(RECIP);

  logic             seen, lvl_q, sel_q, armed;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    prod;
  logic             lvl, lvl_start, lvl_end;

  assign lvl       = din ^ sel_low;
  assign lvl_start = seen && lvl && !lvl_q;
  assign lvl_end   = seen && lvl_q && !lvl;
  assign prod      = PW'(ref_q) * RECIP_V;

  always_ff @(posedge clk) begin
    if (rst || off) begin
      seen  <= 1'b0;
      lvl_q <= 1'b0;
      sel_q <= sel_low;
      armed <= 1'b0;
      cnt   <= '0;
      ref_q <= '0;
      win   <= '0;
    end else begin
      seen  <= 1'b1;
      lvl_q <= lvl;
      sel_q <= sel_low;
      if (sel_low != sel_q) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        if (lvl_start) begin
          armed <= 1'b1;
          cnt   <= CNT_W'(1);
        end else if (lvl) begin
          if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
        if (lvl_end && armed) ref_q <= cnt;
      end
      win <= WIN_W'(prod >> SHIFT);
    end
  end

  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (!off && cnt == CMAX && lvl && lvl_q && sel_low == sel_q) |=> cnt == CMAX);
  a_r4_latch: assert property (@(posedge clk) disable iff (rst)
    (!off && lvl_end && armed && sel_low == sel_q) |=> ref_q == $past(cnt));
  a_r11_cleared: assert property (@(posedge clk) disable iff (rst)
    off |=> (ref_q == '0 && win == '0));
endmodule

// File: rtl/crank_edge_filter.sv
module crank_edge_filter #(
  parameter int WIN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             en,
  input  logic             off,
  input  logic [WIN_W-1:0] win,
  output logic             dout
);
  logic [WIN_W-1:0] scnt;

  always_ff @(posedge clk) begin
    if (rst || off) begin
      dout <= 1'b0;
      scnt <= '0;
    end else if (!en) begin
      dout <= din;
      scnt <= '0;
    end else if (din == dout) begin
      scnt <= '0;
    end else if (scnt >= win) begin
      dout <= din;
      scnt <= '0;
    end else begin
      scnt <= scnt + 1'b1;
    end
  end

  a_r11_out_low: assert property (@(posedge clk) disable iff (rst)
    off |=> !dout);
  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    (!off && !en) |=> dout == $past(din));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!off && en && scnt < win) |=> $stable(dout));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!off && din == dout) |=> $stable(dout));
endmodule

// File: rtl/crank_deglitch.sv
module crank_deglitch
  import crank_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int RECIP = 656,
  parameter int SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             dout,
  output logic [CNT_W-1:0] ref_count
);
  localparam int WIN_W = CNT_W - 6;

  cfg_t             cfg;
  logic [WIN_W-1:0] win;

  crank_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  crank_pulse_timer #(.CNT_W(CNT_W), .RECIP(RECIP), .SHIFT(SHIFT)) u_tmr (
    .clk(clk), .rst(rst), .din(din), .off(cfg.cond_off),
    .sel_low(cfg.sel_low), .ref_q(ref_count), .win(win)
  );

  crank_edge_filter #(.WIN_W(WIN_W)) u_flt (
    .clk(clk), .rst(rst), .din(din), .en(cfg.filt_en),
    .off(cfg.cond_off), .win(win), .dout(dout)
  );

  a_r1_reset_out: assert property (@(posedge clk)
    rst |=> (!dout && ref_count == '0 && cfg_rdata == 8'h00));
endmodule

// File: tb/sim_crank_deglitch.sv
`timescale 1ns/1ps
module sim_crank_deglitch;
  localparam int CW = 12;
  logic clk = 0, rst = 1, din = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic dout;
  logic [CW-1:0] ref_count;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  crank_deglitch #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .din(din), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dout(dout), .ref_count(ref_count));

  function automatic int exp_win(input int len);
    int l = (len > (1 << CW) - 1) ? (1 << CW) - 1 : len;
    return l / 100;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); din = v;
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 1234;
    logic prev;
    int p, l, w;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 dout", dout, 0);
    check("R1 ref", ref_count, 0);
    check("R1 cfg", cfg_rdata, 0);
    // R2 readback masks unused bits
    wr(8'hF6);
    check("R2 readback", cfg_rdata, 8'h02);
    wr(8'h00);
    check("R2 clear", cfg_rdata, 8'h00);
    // R3 bypass with random input
    prev = din;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i > 0) check("R3 bypass", dout, prev);
      din = 1'($urandom);
      prev = din;
    end
    // R10 window 0 from reset
    rst = 1; drive(0, 3); rst = 0;
    wr(8'h08);
    drive(0, 5);
    drive(1, 1);
    @(negedge clk);
    check("R10 one-cycle pass", dout, 1);
    din = 0;
    drive(0, 5);
    // R4 measure, R7 window, R8 rising glitches
    drive(1, 1050); drive(0, 500);
    check("R4 high length", ref_count, 1050);
    drive(1, 10);
    @(negedge clk);
    check("R8 reject at window", dout, 0);
    din = 0; drive(0, 20);
    check("R4 short pulse", ref_count, 10);
    drive(1, 1050); drive(0, 500);
    drive(1, 11);
    @(negedge clk);
    check("R8 pass above window", dout, 1);
    din = 0; drive(0, 20);
    // R5 low reference, R9 falling glitches
    wr(8'h0A);
    drive(1, 200); drive(0, 2030); drive(1, 400);
    check("R5 low length", ref_count, 2030);
    check("R9 settled high", dout, 1);
    drive(0, 20);
    @(negedge clk);
    check("R9 reject at window", dout, 1);
    din = 1; drive(1, 50);
    check("R5 short low", ref_count, 20);
    drive(0, 2030); drive(1, 400);
    drive(0, 21);
    @(negedge clk);
    check("R9 pass above window", dout, 0);
    din = 1; drive(1, 50);
    // R6 saturation, R7 boundary
    wr(8'h08);
    drive(0, 100); drive(1, 5000); drive(0, 500);
    check("R6 saturated", ref_count, (1 << CW) - 1);
    w = exp_win(5000);
    drive(1, w);
    @(negedge clk);
    check("R7 saturated window reject", dout, 0);
    din = 0; drive(0, 50);
    // R7 random windows with glitches around them
    for (int k = 0; k < 20; k++) begin
      p = 100 * (3 + int'($urandom % 28)) + int'($urandom % 81);
      w = exp_win(p);
      l = 1 + int'($urandom % (2 * w + 1));
      drive(1, p); drive(0, 300);
      check("R7 random length", ref_count, p);
      drive(1, l);
      @(negedge clk);
      check("R7/R8 random glitch", dout, (l > w) ? 1 : 0);
      din = 0; drive(0, 300);
    end
    // R11 disable
    drive(1, 1050); drive(0, 300); drive(1, 400);
    wr(8'h09);
    @(negedge clk);
    check("R11 out low", dout, 0);
    check("R11 ref cleared", ref_count, 0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check("R11 input ignored", dout, 0);
      din = 1'($urandom);
    end
    check("R11 ref stays 0", ref_count, 0);
    din = 0;
    wr(8'h08);
    drive(0, 5);
    drive(1, 1);
    @(negedge clk);
    check("R11 window restart", dout, 1);
    din = 0; drive(0, 5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule